// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises an interrupt request when a pin set as an input on either of two 8-bit ports moves away from a per-port reference snapshot. The pin values it sees are already synchronised to `clk` and already corrected for polarity. The request is an open-drain pull-down enable: when `irq_od_en` is high, the pad logic pulls the shared active-low interrupt line to ground.

Each port has its own tracker. The tracker is a small state machine with three states:

- `TRK_LOAD` is entered on reset and primes the snapshot from the live pins.
- `TRK_QUIET` means there is no difference between the live pins and the snapshot.
- `TRK_ARMED` means a watched pin differs from its snapshot.

The transitions are named as follows:

- *reset entry* goes to `TRK_LOAD` from any state.
- *prime* goes from `TRK_LOAD` to `TRK_QUIET`.
- *change detect* goes from `TRK_QUIET` to `TRK_ARMED`.
- *read clear* goes from `TRK_ARMED` (or `TRK_QUIET`) to `TRK_QUIET` on that port's read strobe, which also recaptures the snapshot.
- *revert clear* goes from `TRK_ARMED` to `TRK_QUIET` when the watched pins return to the snapshot.

The request is the OR of the two trackers. Port 0 occupies bits 7:0 of every 16-bit bus and port 1 occupies bits 15:8.

Top module: `pchg_irq_top`

## Requirements
- R1: When a watched pin (`pin_dir` bit = 1) differs from the snapshot of its port at a rising edge of `clk`, `irq_od_en` is 1 after that edge. `irq_od_en` is the OR of both ports' pending conditions.
- R2: When the watched pins of a port return to their snapshot value, the port stops contributing to `irq_od_en` after the next rising edge. Without a read strobe, the snapshot never changes.
- R3: A pin with `pin_dir` bit = 0 (output) never causes `irq_od_en`, whatever its level.
- R4: A read strobe `port_rd[p]` sampled at an edge copies the current port-p pins into its snapshot. Port p then contributes nothing after that edge, even when a pin changed in that same cycle.
- R5: A read strobe on one port leaves the pending condition of the other port unchanged.
- R6: Changing a `pin_dir` bit from 0 to 1 while that pin differs from the snapshot sets `irq_od_en` after the next edge.
- R7: While `rst_n` is low, `irq_od_en` is 0 at once (asynchronously). The first edge after release loads both snapshots from the pins, so `irq_od_en` stays 0 during that cycle and the levels present then raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_val | input | 16 | Synchronised, polarity-corrected pin levels; port p in bits [8p+7:8p] |
| pin_dir | input | 16 | Per-pin direction: 1 = input (watched), 0 = output |
| port_rd | input | 2 | Per-port read strobe of the input register, one bit per port |
| irq_od_en | output | 1 | 1 = pull the active-low interrupt line low |

## Verification
The assertions assume that `pin_val`, `pin_dir` and `port_rd` are synchronous to `clk` and settled before each rising edge. They also assume that a read strobe reflects a single register read. The bench changes every input on the falling edge and samples `irq_od_en` on the following falling edge, one register stage after the change. Read strobes are applied as single-cycle pulses, both alone and in the same cycle as a pin change.

// File: rtl/pchg_pkg.sv
package pchg_pkg;

    typedef enum logic [1:0] {
        TRK_LOAD  = 2'd0,
        TRK_QUIET = 2'd1,
        TRK_ARMED = 2'd2
    } trk_state_t;

endpackage

// File: rtl/pchg_port_tracker.sv
module pchg_port_tracker
    import pchg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    input  logic [WIDTH-1:0] watch_i,
    input  logic             rd_stb_i,
    output logic             pending_o
);

    trk_state_t       state_q;
    trk_state_t       state_d;
    logic [WIDTH-1:0] snap_q;
    logic             moved;

    assign moved = |((pins_i ^ snap_q) & watch_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // reference snapshot: primed after reset, refreshed on read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (state_q == TRK_LOAD || rd_stb_i) begin
            snap_q <= pins_i;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_LOAD:  state_d = TRK_QUIET;
            TRK_QUIET: begin
                if (!rd_stb_i && moved) state_d = TRK_ARMED;
            end
            TRK_ARMED: begin
                if (rd_stb_i || !moved) state_d = TRK_QUIET;
            end
            default:   state_d = TRK_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        pending_o = 1'b0;
        unique case (state_q)
            TRK_ARMED: pending_o = 1'b1;
            default:   pending_o = 1'b0;
        endcase
    end

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> !pending_o);

    assert_outputs_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_i == '0) |=> !pending_o);

    assert_snapshot_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TRK_LOAD && !rd_stb_i) |=> $stable(snap_q));

    assert_prime_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_LOAD) |=> !pending_o);

endmodule

// File: rtl/pchg_irq_combine.sv
module pchg_irq_combine #(
    parameter int NUM_PORTS = 2
) (
    input  logic [NUM_PORTS-1:0] pend_i,
    output logic                 od_en_o
);

    always_comb begin
        od_en_o = |pend_i;
    end

endmodule

// File: rtl/pchg_irq_top.sv
module pchg_irq_top #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_val,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_dir,
    input  logic [NUM_PORTS-1:0]        port_rd,
    output logic                        irq_od_en
);

    localparam int BUS_W = NUM_PORTS * PORT_W;

    logic [NUM_PORTS-1:0] port_pend;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pchg_port_tracker #(
            .WIDTH (PORT_W)
        ) trk_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_i    (pin_val[p*PORT_W +: PORT_W]),
            .watch_i   (pin_dir[p*PORT_W +: PORT_W]),
            .rd_stb_i  (port_rd[p]),
            .pending_o (port_pend[p])
        );
    end

    pchg_irq_combine #(
        .NUM_PORTS (NUM_PORTS)
    ) comb_i (
        .pend_i  (port_pend),
        .od_en_o (irq_od_en)
    );

    assert_reset_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_od_en);

    assert_all_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_dir == {BUS_W{1'b0}}) |=> !irq_od_en);

    assert_all_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&port_rd) |=> !irq_od_en);

endmodule

// File: tb/pchg_irq_top_tb_top.sv
`timescale 1ns/1ps
module pchg_irq_top_tb_top;

    typedef struct packed {
        logic [15:0] pv;
        logic [15:0] dir;
        logic [1:0]  rd;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{16'h3C3C, 16'hFFFF, 2'b00, 1'b0, 4'd7}, // R7 levels at release raise nothing
        '{16'h3C3D, 16'hFFFF, 2'b00, 1'b1, 4'd1}, // R1 port0 bit0 moves
        '{16'h3C3C, 16'hFFFF, 2'b00, 1'b0, 4'd2}, // R2 back to snapshot
        '{16'h3C3D, 16'hFFFF, 2'b01, 1'b0, 4'd4}, // R4 change and read same cycle
        '{16'h3C3D, 16'hFFFF, 2'b00, 1'b0, 4'd4}, // R4 new snapshot holds
        '{16'h3C3C, 16'hFFFF, 2'b00, 1'b1, 4'd1}, // R1 differs from new snapshot
        '{16'h3C3C, 16'hFFFF, 2'b01, 1'b0, 4'd4}, // R4 read clears
        '{16'hFF3C, 16'h00FF, 2'b00, 1'b0, 4'd3}, // R3 port1 outputs move
        '{16'hFF3C, 16'hFFFF, 2'b00, 1'b1, 4'd6}, // R6 outputs become inputs
        '{16'hFF3C, 16'hFFFF, 2'b01, 1'b1, 4'd5}, // R5 port0 read keeps port1
        '{16'hFF3C, 16'hFFFF, 2'b10, 1'b0, 4'd4}, // R4 port1 read
        '{16'h7F3C, 16'h7FFF, 2'b00, 1'b0, 4'd3}, // R3 single output pin
        '{16'h7F3C, 16'hFFFF, 2'b00, 1'b1, 4'd6}, // R6 pin turned input
        '{16'hFF3C, 16'hFFFF, 2'b00, 1'b0, 4'd2}, // R2 pin returns
        '{16'hFE3D, 16'hFFFF, 2'b00, 1'b1, 4'd1}, // R1 both ports move
        '{16'hFE3D, 16'hFFFF, 2'b01, 1'b1, 4'd5}, // R5 port1 still pending
        '{16'hFE3D, 16'hFFFF, 2'b10, 1'b0, 4'd4}, // R4 port1 read clears
        '{16'hFE3D, 16'hFFFF, 2'b00, 1'b0, 4'd4}  // R4 both quiet
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_val = 16'h3C3C;
    logic [15:0] pin_dir = 16'hFFFF;
    logic [1:0]  port_rd = 2'b00;
    logic        irq_od_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pchg_irq_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_val   (pin_val),
        .pin_dir   (pin_dir),
        .port_rd   (port_rd),
        .irq_od_en (irq_od_en)
    );

    task automatic chk(input logic act, input logic exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: irq_od_en actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(irq_od_en, 1'b0, 7, "held in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_od_en, 1'b0, 7, "prime cycle");

        for (int i = 0; i < NV; i++) begin
            pin_val = VECS[i].pv;
            pin_dir = VECS[i].dir;
            port_rd = VECS[i].rd;
            @(negedge clk);
            chk(irq_od_en, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end
        port_rd = 2'b00;

        // R1 pending before a mid-run reset
        pin_val = 16'hFE3C;
        @(negedge clk);
        chk(irq_od_en, 1'b1, 1, "pending before reset");
        #1;
        rst_n = 1'b0;
        #1;
        chk(irq_od_en, 1'b0, 7, "asynchronous clear");
        pin_val = 16'h1234;
        repeat (2) @(negedge clk);
        chk(irq_od_en, 1'b0, 7, "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_od_en, 1'b0, 7, "prime after mid-run reset");
        @(negedge clk);
        chk(irq_od_en, 1'b0, 7, "pins at release loaded");
        pin_val = 16'h1235;
        @(negedge clk);
        chk(irq_od_en, 1'b1, 1, "change after reload");
        pin_val = 16'h1234;
        @(negedge clk);
        chk(irq_od_en, 1'b0, 2, "revert after reload");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 8);
                failures++;
                checks++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule